// File: doc/BRIEF.md
# Root Port Error Message Logger

This block sits beside the error-message path of a PCI Express-style root port. Each message reaches it as a one-cycle valid strobe. The strobe carries a two-bit severity code, a 16-bit requester ID and a flag marking a message the port raised about itself. The block splits the traffic into two classes: correctable, and uncorrectable (non-fatal or fatal). For each class it records whether a first error has been seen and whether further errors followed. It captures the requester ID of the first message in each class only. It also notes whether the first uncorrectable error was fatal.

Software reads a five-bit sticky status word and a 32-bit source-ID word. It clears status bits by writing ones to them. A cleared first-error bit re-arms its class, so the next message of that class is logged as a first error again. A self-raised message is logged with an ID built from the configured local bus number, the port's device number and function 0.

Two resets are provided. The power-good reset clears all of the logged state. The ordinary functional reset only empties the internal decode stage, so logged errors survive it. A message is decoded into a register stage on the first clock edge and reaches the status and ID registers on the second.

Top module: `rp_err_logger`

## Requirements
- R1: A correctable message (kind 2'b00) that finds status bit 0 clear sets bit 0 and stores its ID in source-ID bits 15:0.
- R2: A correctable message that finds bit 0 set sets bit 1 and leaves source-ID bits 15:0 unchanged.
- R3: A non-fatal (kind 2'b01) or fatal (kind 2'b11) message that finds bit 2 clear sets bit 2 and stores its ID in source-ID bits 31:16.
- R4: A non-fatal or fatal message that finds bit 2 set sets bit 3 and leaves source-ID bits 31:16 and bit 4 unchanged.
- R5: Bit 4 is set only when bit 2 goes from clear to set on a fatal message. A non-fatal first error leaves bit 4 as it was.
- R6: When msg_virt is 1, the logged ID is {cfg_bus, DEV_NUM, 3'b000}, with bus in bits 15:8, device in bits 7:3 and function in bits 2:0, instead of msg_rid.
- R7: A cycle with sw_wr_en high clears every status bit whose sw_wr_data bit is 1 and leaves the other bits alone. The source-ID word cannot be written.
- R8: When a hardware set and a software clear hit the same bit in the same cycle, the set wins. The first-or-later decision uses the status from before that cycle: a correctable message arriving while bit 0 is set and being cleared sets bit 1 and leaves bit 0 cleared.
- R9: After software clears bit 0 or bit 2, the next message of that class counts as a first error again and overwrites the matching ID field.
- R10: A message with the reserved kind 2'b10, or any cycle with msg_vld low, changes neither status nor source ID.
- R11: pwr_rst clears status and source ID to 0. rst leaves both unchanged.
- R12: Status and source ID show a message after the second rising edge following the cycle in which msg_vld was sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Functional reset, synchronous, active high; empties the decode stage only |
| pwr_rst | input | 1 | Power-good reset, synchronous, active high; clears all logged state |
| cfg_bus | input | BUS_W | Configured local bus number used for self-raised messages |
| msg_vld | input | 1 | One-cycle strobe marking an incoming error message |
| msg_kind | input | 2 | 00 correctable, 01 non-fatal, 11 fatal, 10 reserved |
| msg_rid | input | BUS_W+DEV_W+FN_W | Requester ID of the message |
| msg_virt | input | 1 | Message was raised by the port itself |
| sw_wr_en | input | 1 | Software write strobe to the status word |
| sw_wr_data | input | 5 | Write-one-to-clear mask for the status bits |
| sts_q | output | 5 | Status: 0 first corr, 1 later corr, 2 first uncorr, 3 later uncorr, 4 first uncorr was fatal |
| srcid_q | output | 2*(BUS_W+DEV_W+FN_W) | Source IDs: 31:16 first uncorrectable, 15:0 first correctable |

## Verification
The bench builds the block with DEV_NUM set to 9 rather than the default 0, and drives cfg_bus with 8'hA5. With these values the substituted self ID (16'hA548) differs from both zero and any requester ID used, so a wrong field position or a missing substitution is visible at the source-ID port. Bus, device and function widths keep their defaults. The 16-bit ID therefore splits 8/5/3, as the ID-building requirement states.

// File: rtl/rp_err_pkg.sv
package rp_err_pkg;

  typedef enum logic [1:0] {
    KIND_COR = 2'b00,
    KIND_NF  = 2'b01,
    KIND_RSV = 2'b10,
    KIND_FAT = 2'b11
  } msg_kind_e;

  localparam int STS_W     = 5;
  localparam int NCLASS    = 2;
  localparam int CLS_COR   = 0;
  localparam int CLS_UNC   = 1;
  localparam int BIT_FATAL = 4;

endpackage

// File: rtl/rp_err_decode.sv
module rp_err_decode #(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int DEV_NUM = 0,
  localparam int RID_W  = BUS_W + DEV_W + FN_W
) (
  input  logic             clk,
  input  logic             srst,
  input  logic             msg_vld,
  input  logic [1:0]       msg_kind,
  input  logic [RID_W-1:0] msg_rid,
  input  logic             msg_virt,
  input  logic [BUS_W-1:0] cfg_bus,
  output logic             cor_evt,
  output logic             unc_evt,
  output logic             fat_evt,
  output logic [RID_W-1:0] evt_id
);
  import rp_err_pkg::*;

  logic [RID_W-1:0] self_id;
  logic             is_cor, is_unc;

  assign self_id = {cfg_bus, DEV_W'(DEV_NUM), {FN_W{1'b0}}};
  assign is_cor  = msg_vld && (msg_kind == KIND_COR);
  assign is_unc  = msg_vld && ((msg_kind == KIND_NF) || (msg_kind == KIND_FAT));

  always_ff @(posedge clk) begin
    if (srst) begin
      cor_evt <= 1'b0;
      unc_evt <= 1'b0;
      fat_evt <= 1'b0;
      evt_id  <= '0;
    end else begin
      cor_evt <= is_cor;
      unc_evt <= is_unc;
      fat_evt <= msg_vld && (msg_kind == KIND_FAT);
      evt_id  <= msg_virt ? self_id : msg_rid;
    end
  end

endmodule

// File: rtl/rp_err_class.sv
module rp_err_class #(
  parameter int ID_W = 16
) (
  input  logic            clk,
  input  logic            prst,
  input  logic            evt,
  input  logic [ID_W-1:0] evt_id,
  input  logic            clr_first,
  input  logic            clr_multi,
  output logic            first_q,
  output logic            multi_q,
  output logic [ID_W-1:0] id_q,
  output logic            first_rise
);

  logic set_first, set_multi;

  assign set_first  = evt && !first_q;
  assign set_multi  = evt &&  first_q;
  assign first_rise = set_first;

  always_ff @(posedge clk) begin
    if (prst) begin
      first_q <= 1'b0;
      multi_q <= 1'b0;
      id_q    <= '0;
    end else begin
      first_q <= set_first | (first_q & ~clr_first);
      multi_q <= set_multi | (multi_q & ~clr_multi);
      if (set_first) id_q <= evt_id;
    end
  end

endmodule

// File: rtl/rp_err_logger.sv
module rp_err_logger #(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int DEV_NUM = 0,
  localparam int RID_W  = BUS_W + DEV_W + FN_W,
  localparam int SRC_W  = 2 * RID_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          pwr_rst,
  input  logic [BUS_W-1:0]              cfg_bus,
  input  logic                          msg_vld,
  input  logic [1:0]                    msg_kind,
  input  logic [RID_W-1:0]              msg_rid,
  input  logic                          msg_virt,
  input  logic                          sw_wr_en,
  input  logic [rp_err_pkg::STS_W-1:0]  sw_wr_data,
  output logic [rp_err_pkg::STS_W-1:0]  sts_q,
  output logic [SRC_W-1:0]              srcid_q
);
  import rp_err_pkg::*;

  logic             cor_evt, unc_evt, fat_evt;
  logic [RID_W-1:0] evt_id;
  logic [STS_W-1:0] clr;
  logic             cls_evt   [NCLASS];
  logic             cls_first [NCLASS];
  logic             cls_multi [NCLASS];
  logic             cls_rise  [NCLASS];
  logic [RID_W-1:0] cls_id    [NCLASS];
  logic             fatal_q;

  rp_err_decode #(
    .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DEV_NUM(DEV_NUM)
  ) u_dec (
    .clk(clk), .srst(rst | pwr_rst),
    .msg_vld(msg_vld), .msg_kind(msg_kind), .msg_rid(msg_rid),
    .msg_virt(msg_virt), .cfg_bus(cfg_bus),
    .cor_evt(cor_evt), .unc_evt(unc_evt), .fat_evt(fat_evt), .evt_id(evt_id)
  );

  assign clr = sw_wr_en ? sw_wr_data : '0;
  assign cls_evt[CLS_COR] = cor_evt;
  assign cls_evt[CLS_UNC] = unc_evt;

  for (genvar g = 0; g < NCLASS; g++) begin : g_cls
    rp_err_class #(.ID_W(RID_W)) u_cls (
      .clk(clk), .prst(pwr_rst),
      .evt(cls_evt[g]), .evt_id(evt_id),
      .clr_first(clr[2*g]), .clr_multi(clr[2*g+1]),
      .first_q(cls_first[g]), .multi_q(cls_multi[g]),
      .id_q(cls_id[g]), .first_rise(cls_rise[g])
    );
    assign sts_q[2*g]   = cls_first[g];
    assign sts_q[2*g+1] = cls_multi[g];
    assign srcid_q[g*RID_W +: RID_W] = cls_id[g];
  end

  always_ff @(posedge clk) begin
    if (pwr_rst) fatal_q <= 1'b0;
    else         fatal_q <= (cls_rise[CLS_UNC] & fat_evt) | (fatal_q & ~clr[BIT_FATAL]);
  end

  assign sts_q[BIT_FATAL] = fatal_q;

endmodule

// File: rtl/rp_err_logger_chk.sv
module rp_err_logger_chk #(
  parameter int BUS_W   = 8,
  parameter int DEV_W   = 5,
  parameter int FN_W    = 3,
  parameter int DEV_NUM = 0,
  localparam int RID_W  = BUS_W + DEV_W + FN_W,
  localparam int SRC_W  = 2 * RID_W
) (
  input logic               clk,
  input logic               rst,
  input logic               pwr_rst,
  input logic [BUS_W-1:0]   cfg_bus,
  input logic               msg_vld,
  input logic [1:0]         msg_kind,
  input logic [RID_W-1:0]   msg_rid,
  input logic               msg_virt,
  input logic               sw_wr_en,
  input logic [4:0]         sw_wr_data,
  input logic [4:0]         sts_q,
  input logic [SRC_W-1:0]   srcid_q
);
  logic             cor_p, unc_p, fat_p;
  logic [RID_W-1:0] id_p;

  always_ff @(posedge clk) begin
    if (rst || pwr_rst) begin
      cor_p <= 1'b0;
      unc_p <= 1'b0;
      fat_p <= 1'b0;
      id_p  <= '0;
    end else begin
      cor_p <= msg_vld && msg_kind == 2'b00;
      unc_p <= msg_vld && msg_kind[0];
      fat_p <= msg_vld && msg_kind == 2'b11;
      id_p  <= msg_virt ? {cfg_bus, DEV_W'(DEV_NUM), {FN_W{1'b0}}} : msg_rid;
    end
  end

  // R1
  first_cor_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    cor_p && !sts_q[0] |=> sts_q[0] && srcid_q[RID_W-1:0] == $past(id_p));

  // R2
  later_cor_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    cor_p && sts_q[0] |=> sts_q[1] && $stable(srcid_q[RID_W-1:0]));

  // R3
  first_unc_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    unc_p && !sts_q[2] |=> sts_q[2] && srcid_q[SRC_W-1:RID_W] == $past(id_p));

  // R4
  later_unc_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    unc_p && sts_q[2] |=> sts_q[3] && $stable(srcid_q[SRC_W-1:RID_W]));

  // R5
  fatal_mark_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    unc_p && fat_p && !sts_q[2] |=> sts_q[4]);

  // R5
  fatal_only_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !(unc_p && fat_p && !sts_q[2]) |=> !$rose(sts_q[4]));

  // R7
  w1c_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    sw_wr_en && !cor_p && !unc_p |=> (sts_q & $past(sw_wr_data)) == 5'd0);

  // R10 R11
  idle_chk: assert property (@(posedge clk) disable iff (pwr_rst)
    !sw_wr_en && !cor_p && !unc_p |=> $stable(sts_q) && $stable(srcid_q));

endmodule

bind rp_err_logger rp_err_logger_chk #(
  .BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DEV_NUM(DEV_NUM)
) u_chk (
  .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .cfg_bus(cfg_bus),
  .msg_vld(msg_vld), .msg_kind(msg_kind), .msg_rid(msg_rid),
  .msg_virt(msg_virt), .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data),
  .sts_q(sts_q), .srcid_q(srcid_q)
);

// File: tb/rp_err_logger_test.sv
module rp_err_logger_test;
  localparam int BUS_W = 8;
  localparam int DEV_W = 5;
  localparam int FN_W  = 3;
  localparam int DEVN  = 9;
  localparam int RID_W = BUS_W + DEV_W + FN_W;

  typedef struct {
    string       tag;
    logic [4:0]  sts;
    logic [31:0] sid;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1, pwr_rst = 1'b1;
  logic [7:0]  cfg_bus = 8'hA5;
  logic        msg_vld = 1'b0, msg_virt = 1'b0, sw_wr_en = 1'b0;
  logic [1:0]  msg_kind = 2'b00;
  logic [15:0] msg_rid = '0;
  logic [4:0]  sw_wr_data = '0;
  logic [4:0]  sts_q;
  logic [31:0] srcid_q;

  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];
  event chk_ev;
  logic [4:0]  m_sts = '0;
  logic [31:0] m_sid = '0;

  always #5 clk = ~clk;

  rp_err_logger #(.BUS_W(BUS_W), .DEV_W(DEV_W), .FN_W(FN_W), .DEV_NUM(DEVN)) uut (
    .clk(clk), .rst(rst), .pwr_rst(pwr_rst), .cfg_bus(cfg_bus),
    .msg_vld(msg_vld), .msg_kind(msg_kind), .msg_rid(msg_rid), .msg_virt(msg_virt),
    .sw_wr_en(sw_wr_en), .sw_wr_data(sw_wr_data), .sts_q(sts_q), .srcid_q(srcid_q)
  );

  task automatic push(input string tag);
    exp_t e;
    e.tag = tag; e.sts = m_sts; e.sid = m_sid;
    q.push_back(e);
    -> chk_ev;
  endtask

  // Model from the requirements: hardware sets win over clears, decision on old value.
  task automatic model(input bit vld, input logic [1:0] kind, input logic [15:0] rid,
                       input bit virt, input bit wr, input logic [4:0] wd);
    logic [4:0]  hs;
    logic [4:0]  cl;
    logic [15:0] id;
    bit cor, unc, fat;
    hs = '0;
    cor = vld && kind == 2'b00;
    unc = vld && (kind == 2'b01 || kind == 2'b11);
    fat = vld && kind == 2'b11;
    id  = virt ? {cfg_bus, 5'(DEVN), 3'b000} : rid;
    cl  = wr ? wd : 5'd0;
    if (cor) begin
      if (!m_sts[0]) begin hs[0] = 1'b1; m_sid[15:0] = id; end
      else hs[1] = 1'b1;
    end
    if (unc) begin
      if (!m_sts[2]) begin hs[2] = 1'b1; hs[4] = fat; m_sid[31:16] = id; end
      else hs[3] = 1'b1;
    end
    m_sts = (m_sts & ~cl) | hs;
  endtask

  task automatic op(input string tag, input bit vld, input logic [1:0] kind,
                    input logic [15:0] rid, input bit virt, input bit wr,
                    input logic [4:0] wd);
    @(negedge clk);
    msg_vld = vld; msg_kind = kind; msg_rid = rid; msg_virt = virt;
    @(negedge clk);
    msg_vld = 1'b0; msg_virt = 1'b0;
    sw_wr_en = wr; sw_wr_data = wd;
    @(negedge clk);
    sw_wr_en = 1'b0; sw_wr_data = '0;
    model(vld, kind, rid, virt, wr, wd);
    push(tag);
  endtask

  // Monitor: compares each expected item against the ports.
  initial begin
    forever begin
      @(chk_ev);
      while (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        n_chk++;
        if (sts_q !== e.sts) begin
          n_fail++;
          $display("FAIL %s status: actual %h expected %h", e.tag, sts_q, e.sts);
        end
        n_chk++;
        if (srcid_q !== e.sid) begin
          n_fail++;
          $display("FAIL %s source id: actual %h expected %h", e.tag, srcid_q, e.sid);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0; pwr_rst = 1'b0;
    @(negedge clk);
    push("R11 reset state");
    op("R1 R12 first correctable", 1, 2'b00, 16'h1234, 0, 0, 5'h00);
    op("R2 later correctable", 1, 2'b00, 16'h5678, 0, 0, 5'h00);
    op("R3 first non-fatal", 1, 2'b01, 16'h0A0B, 0, 0, 5'h00);
    op("R4 R5 fatal after non-fatal", 1, 2'b11, 16'h0C0D, 0, 0, 5'h00);
    op("R10 reserved kind ignored", 1, 2'b10, 16'hFFFF, 0, 0, 5'h00);
    op("R10 valid low ignored", 0, 2'b11, 16'hEEEE, 0, 0, 5'h00);
    op("R7 clear uncorrectable bits", 0, 2'b00, 16'h0000, 0, 1, 5'h0C);
    op("R5 R6 R9 fatal virtual rearmed", 1, 2'b11, 16'h7777, 1, 0, 5'h00);
    op("R8 clear all with correctable", 1, 2'b00, 16'h4321, 0, 1, 5'h1F);
    op("R9 correctable after clear", 1, 2'b00, 16'h9999, 0, 0, 5'h00);
    op("R8 set wins on bit1", 1, 2'b00, 16'h2222, 0, 1, 5'h02);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk); push("R11 functional reset keeps log");
    @(negedge clk); pwr_rst = 1'b1;
    @(negedge clk); pwr_rst = 1'b0;
    m_sts = '0; m_sid = '0;
    @(negedge clk); push("R11 power reset clears log");
    op("R6 virtual correctable", 1, 2'b00, 16'h3333, 1, 0, 5'h00);
    op("R3 R5 non-fatal leaves bit4", 1, 2'b01, 16'h0101, 0, 0, 5'h00);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule